// File: doc/BRIEF.md
# Half-Duplex Host Link Arbiter (MII / RMII, PHY Side)

This block sits at the PHY end of a host link whose pins can carry both directions at once, but which is run one direction at a time. Host frames arriving on the transmit pins are packed into bytes and written to a transmit buffer port. Frames waiting at a receive frame source are serialised back to the host with an Ethernet preamble and start-of-frame delimiter placed ahead of the payload. The block drives carrier sense, receive data valid and receive error. It also decides which direction owns the link, and receive is given priority.

Carrier sense serves two purposes. It stays high after a host frame until the transmit buffer reports that it can take another packet. It is also raised on its own to claim the link for a pending receive frame. Receive data valid follows one interframe gap later. If the host starts a frame inside that gap, receive waits until the host frame ends and a fresh gap has passed. A mode input selects nibble-wide MII or dibit-wide RMII. In RMII, a decode error is signalled by overwriting the data with a fixed dibit rather than by a separate error pin.

Top module: `hdx_link_arbiter`

## Requirements
- R1: When tx_en is sampled high while crs is low, crs is high from the next cycle. It stays high on every cycle after one in which tx_en was high. After tx_en falls, crs stays high until tbuf_ready is sampled high, and then drops on the following cycle.
- R2: rx_dv is never high in a cycle in which tx_en is high.
- R3: With the link idle and rx_pend sampled high, crs rises on the next cycle. rx_dv rises exactly GAP cycles after crs. GAP is 24 cycles in MII mode and 48 cycles in RMII mode.
- R4: If tx_en is raised while crs is high and rx_dv is low, rx_dv is held off until tx_en has been low for GAP consecutive cycles. The host frame sent in that window is still written to the buffer port.
- R5: After the last symbol of a received frame, crs falls on the next cycle unless rx_pend or tbuf_full is high. If rx_pend is high, a new gap starts with crs held high and the next frame follows. If only tbuf_full is high, crs stays high until tbuf_full is low.
- R6: A received frame is sent as 7 bytes of 0x55, one byte of 0xD5 and then the payload bytes in order. Each byte goes out least significant symbol first, one symbol per cycle. In MII the symbol is on rxd[3:0]; in RMII it is on rxd[1:0] with rxd[3:2] at 0.
- R7: In RMII mode, the first cycle of rx_dv carries rxd = 00 ahead of the preamble, and rx_er is never asserted.
- R8: In RMII mode, from the first symbol of a payload byte flagged by rx_err until rx_dv falls, rxd[1:0] is 2'b10.
- R9: In MII mode, rx_er is high during both nibbles of a payload byte flagged by rx_err and low otherwise. The nibbles of that byte pass through unchanged.
- R10: Symbols sampled while tx_en is high are packed least significant first into bytes. tbuf_we is high for one cycle, the cycle after the last symbol of a byte is sampled, with that byte on tbuf_byte. tbuf_sof marks the first byte of a frame. txd has no effect while tx_en is low, including RMII idle 00.
- R11: tbuf_eof is high for one cycle, the cycle after tx_en is first sampled low following a frame. A trailing partial byte is never written.
- R12: While reset is asserted, crs, rx_dv, rx_er, rxd, tbuf_we, tbuf_sof, tbuf_eof and rx_take are all 0.
- R13: rx_take is high once per payload byte, in the cycle that carries the last symbol of the SFD or of the previous payload byte. rx_byte, rx_err and rx_last are sampled at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock, one symbol per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| rmii_mode | input | 1 | 0 = nibble (MII), 1 = dibit (RMII); change only while idle |
| tx_en | input | 1 | Host transmit enable |
| txd | input | 4 | Host transmit symbol (RMII uses bits 1:0) |
| tbuf_we | output | 1 | Transmit buffer byte strobe |
| tbuf_byte | output | 8 | Packed transmit byte |
| tbuf_sof | output | 1 | Marks the first byte of a host frame |
| tbuf_eof | output | 1 | One-cycle end-of-frame strobe |
| tbuf_ready | input | 1 | Transmit buffer can take another packet |
| tbuf_full | input | 1 | Transmit buffer full |
| rx_pend | input | 1 | Receive source holds a frame byte |
| rx_byte | input | 8 | Current receive payload byte |
| rx_last | input | 1 | Current byte ends its frame |
| rx_err | input | 1 | Current byte carried a decode error |
| rx_take | output | 1 | Receive byte consumed at this edge |
| crs | output | 1 | Carrier sense to host |
| rx_dv | output | 1 | Receive data valid to host |
| rx_er | output | 1 | Receive error to host (MII only) |
| rxd | output | 4 | Receive symbol to host |

## Verification
The hardest case to reach is deferral. The host has to raise tx_en after crs has gone up for a pending frame, but before the gap ends. The stimulus queues a receive frame, waits until crs is seen high with rx_dv still low, and a few cycles later starts a host frame. The bench then checks that rx_dv waits a full gap after tx_en falls, and that the host bytes still reach the buffer port. Holding crs after a frame with the buffer full, and chaining two queued frames with no crs drop between them, are set up by driving tbuf_full and queueing frames before the claim.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int          BYTE_W   = 8;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;

  typedef enum logic [2:0] {
    L_IDLE, L_TX, L_DRAIN, L_GAP, L_XFER, L_HOLD
  } link_st_t;

  typedef enum logic [1:0] {
    P_LEAD, P_PRE, P_PAY
  } rx_ph_t;

  // index of the final symbol in a byte for the selected width
  function automatic logic [1:0] sym_last(input logic rmii);
    return rmii ? 2'd3 : 2'd1;
  endfunction
endpackage

// File: rtl/hdx_tx_pack.sv
module hdx_tx_pack
  import hdx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rmii_mode,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       wr,
  output logic [7:0] wbyte,
  output logic       sof,
  output logic       eof
);
  logic       in_frame, in_frame_n;
  logic [1:0] sym, sym_n;
  logic [7:0] acc, acc_n, merged;
  logic       first, first_n, eff_first;
  logic       wr_n, sof_n, eof_n;
  logic [7:0] wbyte_n;

  always_comb begin
    merged = acc;
    if (rmii_mode) merged[{sym, 1'b0} +: 2]     = txd[1:0];
    else           merged[{sym[0], 2'b00} +: 4] = txd;
    eff_first  = in_frame ? first : 1'b1;
    in_frame_n = in_frame;
    sym_n      = sym;
    acc_n      = acc;
    first_n    = first;
    wr_n       = 1'b0;
    sof_n      = 1'b0;
    eof_n      = 1'b0;
    wbyte_n    = wbyte;
    if (tx_en) begin
      in_frame_n = 1'b1;
      acc_n      = merged;
      if (sym == sym_last(rmii_mode)) begin
        sym_n   = '0;
        wr_n    = 1'b1;
        wbyte_n = merged;
        sof_n   = eff_first;
        first_n = 1'b0;
      end else begin
        sym_n   = sym + 2'd1;
        first_n = eff_first;
      end
    end else if (in_frame) begin
      in_frame_n = 1'b0;
      eof_n      = 1'b1;
      sym_n      = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      sym      <= '0;
      acc      <= '0;
      first    <= 1'b0;
      wr       <= 1'b0;
      sof      <= 1'b0;
      eof      <= 1'b0;
      wbyte    <= '0;
    end else begin
      in_frame <= in_frame_n;
      sym      <= sym_n;
      acc      <= acc_n;
      first    <= first_n;
      wr       <= wr_n;
      sof      <= sof_n;
      eof      <= eof_n;
      if (wr_n) wbyte <= wbyte_n;
    end
  end

  // R10: a byte strobe only follows a cycle in which tx_en was sampled high
  assert_we_after_txen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> $past(tx_en));
  // R11: end-of-frame strobe only after tx_en was sampled low
  assert_eof_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    eof |-> !$past(tx_en));
endmodule

// File: rtl/hdx_rx_serial.sv
module hdx_rx_serial
  import hdx_pkg::*;
#(
  parameter int PRE_LEN = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rmii_mode,
  input  logic       start,
  input  logic [7:0] rx_byte,
  input  logic       rx_last,
  input  logic       rx_err,
  output logic       active,
  output logic       take,
  output logic       done,
  output logic [3:0] rxd,
  output logic       rx_er
);
  localparam int BW = $clog2(PRE_LEN + 1);

  rx_ph_t        ph, ph_n;
  logic          act_n;
  logic [1:0]    sym, sym_n;
  logic [BW-1:0] bidx, bidx_n;
  logic [7:0]    cur, cur_n;
  logic          cur_err, cur_err_n, cur_last, cur_last_n, sticky, sticky_n;
  logic          at_last;
  logic [3:0]    sym_val;

  always_comb begin
    at_last = active && (ph != P_LEAD) && (sym == sym_last(rmii_mode));
    take    = at_last && (((ph == P_PRE) && (bidx == BW'(PRE_LEN))) ||
                          ((ph == P_PAY) && !cur_last));
    done    = at_last && (ph == P_PAY) && cur_last;
    act_n = active; ph_n = ph; sym_n = sym; bidx_n = bidx; cur_n = cur;
    cur_err_n = cur_err; cur_last_n = cur_last; sticky_n = sticky;
    if (start) begin
      act_n = 1'b1; ph_n = rmii_mode ? P_LEAD : P_PRE;
      sym_n = '0; bidx_n = '0; cur_n = PRE_BYTE;
      cur_err_n = 1'b0; cur_last_n = 1'b0; sticky_n = 1'b0;
    end else if (active) begin
      if (ph == P_LEAD) begin
        ph_n = P_PRE;
      end else if (!at_last) begin
        sym_n = sym + 2'd1;
      end else begin
        sym_n = '0;
        if (take) begin
          ph_n = P_PAY; cur_n = rx_byte; cur_err_n = rx_err;
          cur_last_n = rx_last; sticky_n = sticky | rx_err;
        end else if (done) begin
          act_n = 1'b0;
        end else begin
          bidx_n = bidx + 1'b1;
          cur_n  = (bidx == BW'(PRE_LEN - 1)) ? SFD_BYTE : PRE_BYTE;
        end
      end
    end
    sym_val = rmii_mode ? {2'b00, cur[{sym, 1'b0} +: 2]} : cur[{sym[0], 2'b00} +: 4];
    if (!active || ph == P_LEAD)                  rxd = 4'b0000;
    else if (rmii_mode && sticky && ph == P_PAY)  rxd = 4'b0010;
    else                                          rxd = sym_val;
    rx_er = active && !rmii_mode && (ph == P_PAY) && cur_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; ph <= P_LEAD; sym <= '0; bidx <= '0; cur <= '0;
      cur_err <= 1'b0; cur_last <= 1'b0; sticky <= 1'b0;
    end else begin
      active <= act_n; ph <= ph_n; sym <= sym_n; bidx <= bidx_n; cur <= cur_n;
      cur_err <= cur_err_n; cur_last <= cur_last_n; sticky <= sticky_n;
    end
  end

  // R7: the dibit mode never uses the error pin
  assert_rmii_no_rxer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rmii_mode |-> !rx_er);
  // R8: once an errored byte is on the wire in RMII, output is the forced dibit
  assert_rmii_forced_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rmii_mode && active && sticky && ph == P_PAY) |-> (rxd == 4'b0010));
endmodule

// File: rtl/hdx_link_ctrl.sv
module hdx_link_ctrl
  import hdx_pkg::*;
#(
  parameter int GAP_MII  = 24,
  parameter int GAP_RMII = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rmii_mode,
  input  logic tx_en,
  input  logic rx_pend,
  input  logic tbuf_ready,
  input  logic tbuf_full,
  input  logic xfer_done,
  output logic crs,
  output logic start
);
  localparam int GMAX = (GAP_MII > GAP_RMII) ? GAP_MII : GAP_RMII;
  localparam int CW   = $clog2(GMAX + 1);

  link_st_t      st, st_n;
  logic [CW-1:0] cnt, cnt_n, gap_lim;

  always_comb begin
    gap_lim = rmii_mode ? CW'(GAP_RMII - 1) : CW'(GAP_MII - 1);
    st_n  = st;
    cnt_n = cnt;
    start = 1'b0;
    case (st)
      L_IDLE:  if (tx_en) st_n = L_TX;
               else if (rx_pend) begin st_n = L_GAP; cnt_n = '0; end
      L_TX:    if (!tx_en) st_n = L_DRAIN;
      L_DRAIN: if (tbuf_ready) st_n = L_IDLE;
      L_GAP:   if (tx_en) cnt_n = '0;
               else if (cnt == gap_lim) begin st_n = L_XFER; start = 1'b1; end
               else cnt_n = cnt + 1'b1;
      L_XFER:  if (xfer_done) begin
                 if (rx_pend) begin st_n = L_GAP; cnt_n = '0; end
                 else if (tbuf_full) st_n = L_HOLD;
                 else st_n = L_IDLE;
               end
      L_HOLD:  if (rx_pend) begin st_n = L_GAP; cnt_n = '0; end
               else if (!tbuf_full) st_n = L_IDLE;
      default: st_n = L_IDLE;
    endcase
    crs = (st != L_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= L_IDLE;
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end

  // R1: host enable on a free link raises carrier on the next cycle
  assert_crs_follows_txen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_en && !crs) |=> crs);
  // R1: carrier is present after every cycle with tx_en high
  assert_crs_during_tx_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_en) |-> crs);
  // R5: a full transmit buffer after a receive keeps carrier up
  assert_hold_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_done && tbuf_full) |=> crs);
endmodule

// File: rtl/hdx_link_arbiter.sv
module hdx_link_arbiter
  import hdx_pkg::*;
#(
  parameter int GAP_MII  = 24,
  parameter int GAP_RMII = 48,
  parameter int PRE_LEN  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rmii_mode,
  input  logic       tx_en,
  input  logic [3:0] txd,
  output logic       tbuf_we,
  output logic [7:0] tbuf_byte,
  output logic       tbuf_sof,
  output logic       tbuf_eof,
  input  logic       tbuf_ready,
  input  logic       tbuf_full,
  input  logic       rx_pend,
  input  logic [7:0] rx_byte,
  input  logic       rx_last,
  input  logic       rx_err,
  output logic       rx_take,
  output logic       crs,
  output logic       rx_dv,
  output logic       rx_er,
  output logic [3:0] rxd
);
  localparam int GMAX = (GAP_MII > GAP_RMII) ? GAP_MII : GAP_RMII;
  localparam int QW   = $clog2(GMAX + 2);

  logic [1:0] rst_sync;
  logic       rst_q_n;
  logic       start, done;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  hdx_tx_pack u_tx (
    .clk(clk), .rst_n(rst_q_n), .rmii_mode(rmii_mode), .tx_en(tx_en), .txd(txd),
    .wr(tbuf_we), .wbyte(tbuf_byte), .sof(tbuf_sof), .eof(tbuf_eof)
  );

  hdx_link_ctrl #(.GAP_MII(GAP_MII), .GAP_RMII(GAP_RMII)) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .rmii_mode(rmii_mode), .tx_en(tx_en),
    .rx_pend(rx_pend), .tbuf_ready(tbuf_ready), .tbuf_full(tbuf_full),
    .xfer_done(done), .crs(crs), .start(start)
  );

  hdx_rx_serial #(.PRE_LEN(PRE_LEN)) u_rx (
    .clk(clk), .rst_n(rst_q_n), .rmii_mode(rmii_mode), .start(start),
    .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err),
    .active(rx_dv), .take(rx_take), .done(done), .rxd(rxd), .rx_er(rx_er)
  );

  // checker: consecutive cycles of claimed, quiet link before receive starts
  logic [QW-1:0] quiet;
  logic [QW-1:0] gap_need;
  assign gap_need = rmii_mode ? QW'(GAP_RMII) : QW'(GAP_MII);
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)                   quiet <= '0;
    else if (!crs || tx_en || rx_dv) quiet <= '0;
    else if (quiet != {QW{1'b1}})   quiet <= quiet + 1'b1;
  end

  // R2: the two directions never overlap on the pins
  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_dv |-> !tx_en);
  // R3 and R4: a full gap of quiet carrier precedes every receive start
  assert_gap_before_rxdv_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rx_dv) |-> (quiet >= gap_need));
  // R3: receive data is always covered by carrier
  assert_crs_covers_rx_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_dv |-> crs);
  // R13: bytes are only consumed from a source that holds one
  assert_take_needs_byte_R13: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_take |-> rx_pend);
endmodule

// File: tb/sim_hdx_link_arbiter.sv
module sim_hdx_link_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rmii_mode = 1'b0, tx_en = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tbuf_ready = 1'b1, tbuf_full = 1'b0;
  logic       rx_pend = 1'b0, rx_last = 1'b0, rx_err = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       tbuf_we, tbuf_sof, tbuf_eof, rx_take, crs, rx_dv, rx_er;
  logic [7:0] tbuf_byte;
  logic [3:0] rxd;

  always #10 clk = ~clk;

  hdx_link_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .rmii_mode(rmii_mode), .tx_en(tx_en), .txd(txd),
    .tbuf_we(tbuf_we), .tbuf_byte(tbuf_byte), .tbuf_sof(tbuf_sof), .tbuf_eof(tbuf_eof),
    .tbuf_ready(tbuf_ready), .tbuf_full(tbuf_full), .rx_pend(rx_pend),
    .rx_byte(rx_byte), .rx_last(rx_last), .rx_err(rx_err), .rx_take(rx_take),
    .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd)
  );

  int    checks = 0, errors = 0;
  string tag = "R12";
  bit    model_on = 1'b0;

  task automatic chkeq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // receive source: flat queues, frames delimited by the last flag
  int q_byte[$], q_err[$], q_last[$];
  int pushed = 0, takes = 0;

  // behavioural reference
  int ms = 0, cnt = 0;
  int s_rxd[$], s_er[$], s_tk[$];
  int acc = 0, nsym = 0, e_byte = 0;
  bit infr = 0, first = 0, e_we = 0, e_sof = 0, e_eof = 0;
  int w, per, gap, sticky;

  task automatic push_sym(int byte_v, int er, int tk_last, int force_v);
    for (int s = 0; s < per; s++) begin
      s_rxd.push_back(force_v ? 2 : (byte_v >> (s * w)) & ((1 << w) - 1));
      s_er.push_back(er);
      s_tk.push_back((s == per - 1) ? tk_last : 0);
    end
  endtask

  task automatic build_frame();
    if (rmii_mode) begin s_rxd.push_back(0); s_er.push_back(0); s_tk.push_back(0); end
    for (int b = 0; b < 8; b++) push_sym((b < 7) ? 'h55 : 'hD5, 0, (b == 7), 0);
    sticky = 0;
    for (int i = 0; i < q_byte.size(); i++) begin
      sticky = sticky | q_err[i];
      push_sym(q_byte[i], (!rmii_mode) && q_err[i], !q_last[i], rmii_mode && sticky);
      if (q_last[i] != 0) break;
    end
  endtask

  always @(posedge clk) begin
    if (!model_on) begin
      ms = 0; cnt = 0; infr = 0; e_we = 0; e_sof = 0; e_eof = 0;
      s_rxd.delete(); s_er.delete(); s_tk.delete();
    end else begin
      w = rmii_mode ? 2 : 4; per = 8 / w; gap = rmii_mode ? 48 : 24;
      e_we = 0; e_sof = 0; e_eof = 0;
      if (tx_en) begin
        if (!infr) begin infr = 1; nsym = 0; first = 1; acc = 0; end
        acc = acc | ((int'(txd) & ((1 << w) - 1)) << (nsym * w));
        nsym++;
        if (nsym == per) begin
          e_we = 1; e_byte = acc; e_sof = first; first = 0; acc = 0; nsym = 0;
        end
      end else if (infr) begin
        infr = 0; e_eof = 1;
      end
      case (ms)
        0: if (tx_en) ms = 1; else if (rx_pend) begin ms = 3; cnt = 0; end
        1: if (!tx_en) ms = 2;
        2: if (tbuf_ready) ms = 0;
        3: if (tx_en) cnt = 0;
           else if (cnt == gap - 1) begin ms = 4; build_frame(); end
           else cnt++;
        4: begin
             void'(s_rxd.pop_front()); void'(s_er.pop_front()); void'(s_tk.pop_front());
             if (s_rxd.size() == 0) begin
               if (rx_pend) begin ms = 3; cnt = 0; end
               else if (tbuf_full) ms = 5;
               else ms = 0;
             end
           end
        5: if (rx_pend) begin ms = 3; cnt = 0; end else if (!tbuf_full) ms = 0;
        default: ms = 0;
      endcase
      if (rx_take) begin
        takes++;
        if (q_byte.size() > 0) begin
          void'(q_byte.pop_front()); void'(q_err.pop_front()); void'(q_last.pop_front());
        end
      end
    end
  end

  // compare away from the active edge, then refresh the source pins
  always @(negedge clk) begin
    if (model_on) begin
      chkeq(tag, "crs", crs, ms != 0);
      chkeq(tag, "rx_dv", rx_dv, ms == 4);
      chkeq(tag, "rxd", rxd, (ms == 4) ? s_rxd[0] : 0);
      chkeq(tag, "rx_er", rx_er, (ms == 4) ? s_er[0] : 0);
      chkeq(tag, "rx_take", rx_take, (ms == 4) ? s_tk[0] : 0);
      chkeq(tag, "tbuf_we", tbuf_we, e_we);
      chkeq(tag, "tbuf_sof", tbuf_sof, e_sof);
      chkeq(tag, "tbuf_eof", tbuf_eof, e_eof);
      if (e_we) chkeq(tag, "tbuf_byte", tbuf_byte, e_byte);
      chkeq("R2", "rx_dv with tx_en", rx_dv && tx_en, 0);
    end
    rx_pend = (q_byte.size() != 0);
    rx_byte = rx_pend ? 8'(q_byte[0]) : 8'h00;
    rx_err  = rx_pend ? (q_err[0] != 0) : 1'b0;
    rx_last = rx_pend ? (q_last[0] != 0) : 1'b0;
  end

  task automatic queue_rx(int n, int errpos, int seed);
    for (int i = 0; i < n; i++) begin
      q_byte.push_back((seed + i * 29) & 255);
      q_err.push_back(i == errpos);
      q_last.push_back(i == n - 1);
    end
    pushed += n;
  endtask

  task automatic send_tx(int n, int seed, int extra);
    int ww, pp;
    ww = rmii_mode ? 2 : 4; pp = 8 / ww;
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < pp; s++) begin
        @(negedge clk);
        tx_en = 1'b1;
        txd = 4'(((seed + i * 53) & 255) >> (s * ww)) & 4'((1 << ww) - 1);
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk); txd = 4'(e + 1);
    end
    @(negedge clk);
    tx_en = 1'b0; txd = 4'h0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 4) begin
      @(negedge clk);
      if (!crs && q_byte.size() == 0 && !tx_en) q++; else q = 0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired, actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: all outputs quiet in reset
    chkeq("R12", "crs", crs, 0);       chkeq("R12", "rx_dv", rx_dv, 0);
    chkeq("R12", "rx_er", rx_er, 0);   chkeq("R12", "rxd", rxd, 0);
    chkeq("R12", "tbuf_we", tbuf_we, 0); chkeq("R12", "tbuf_sof", tbuf_sof, 0);
    chkeq("R12", "tbuf_eof", tbuf_eof, 0); chkeq("R12", "rx_take", rx_take, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    tag = "R10"; txd = 4'hA;            // txd ignored while tx_en is low
    repeat (6) @(negedge clk); txd = 4'h0;

    tag = "R1"; tbuf_ready = 1'b0;      // carrier held until the buffer is ready
    send_tx(6, 8'h3C, 0);
    repeat (8) @(negedge clk); tbuf_ready = 1'b1;
    wait_idle();

    tag = "R3";  queue_rx(6, -1, 8'h10); wait_idle();
    tag = "R6";  queue_rx(3, -1, 8'hF1); wait_idle();
    tag = "R9";  queue_rx(5, 2, 8'h47);  wait_idle();

    tag = "R4";                           // host frame inside the claim window
    queue_rx(4, -1, 8'h82);
    while (!crs) @(negedge clk);
    repeat (3) @(negedge clk);
    send_tx(4, 8'h19, 0);
    wait_idle();

    tag = "R5";                           // two frames back to back
    queue_rx(3, -1, 8'h05); queue_rx(2, -1, 8'hA0);
    wait_idle();
    tbuf_full = 1'b1; queue_rx(3, -1, 8'h66);
    repeat (90) @(negedge clk);
    tbuf_full = 1'b0;
    wait_idle();

    rmii_mode = 1'b1;
    repeat (2) @(negedge clk);
    tag = "R7";  queue_rx(4, -1, 8'h2B); wait_idle();
    tag = "R8";  queue_rx(6, 1, 8'h93);  wait_idle();
    tag = "R10"; send_tx(3, 8'hC4, 0);   wait_idle();
    tag = "R11"; send_tx(2, 8'h7E, 2);   wait_idle();

    chkeq("R13", "take count", takes, pushed);
    finish_run();
  end
endmodule